// File: doc/BRIEF.md
# Wormhole XY Mesh Router

This block is the switch for one node of a two-dimensional mesh network-on-chip. It has five ports: one toward each neighbour (north, east, south, west) and one toward the node's own network interface. Packets are cut into flits. The head flit names the destination column and row. The router sends each packet along the row first until the column matches, then along the column, and finally delivers it locally. Routing in this fixed order breaks every cycle of channel dependencies, so a mesh built from these routers cannot deadlock.

Switching is wormhole. An output port is claimed by the head flit of a packet and stays tied to that input until the packet's last flit has been accepted downstream. A packet may therefore be spread across several routers at once. When it is blocked, it waits in the small flit buffers along its path. It is never dropped or rerouted. Every link uses valid/ready handshaking, and each input has a two-entry flit buffer, so the link can run at full rate even though the ready signal comes from a register.

The router's own column and row are parameters. When several head flits want the same idle output in one cycle, a round-robin arbiter for that output picks one of them.

Top module: `mesh_router`

## Requirements
- R1: Port index 0 is local, 1 north, 2 east, 3 south and 4 west. Each flit is DATA_W+2 bits wide. The destination column sits in bits [COORD_W-1:0] of a head flit and the destination row in bits [2*COORD_W-1:COORD_W]. A head flit leaves on east when its column is greater than X_POS and on west when it is smaller. When the column equals X_POS, it leaves on north when its row is greater than Y_POS and on south when it is smaller. When both match, it leaves on local.
- R2: The flit kind is held in the top two bits: 00 body, 01 head, 10 tail, 11 single (head and tail at once). A body or tail flit never appears on an output that is not carrying an open packet.
- R3: Once a head flit of a multi-flit packet has claimed an output, that output carries only flits of the same input, in order, until that packet's tail. A head flit never appears on an output while another packet is open there.
- R4: An output is freed in the cycle its tail (or single) flit is accepted. A waiting head flit can be sent on that output in the very next cycle.
- R5: Head flits contending for the same free output are served round robin. After an input wins, every other waiting input is served before that input wins again.
- R6: While out_valid is high and out_ready is low, the flit on that output stays unchanged. No flit is lost or duplicated under any pattern of backpressure.
- R7: Each input accepts flits while its buffer holds fewer than two flits. in_ready is low when the buffer is full. Flits from one input leave in the order they arrived.
- R8: With all ready signals high, a packet streams through the router at one flit per cycle with no gaps.
- R9: While reset is asserted, and right after it, every out_valid is low and every in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Flit offered on each input port |
| in_flit | input | 5*(DATA_W+2) | Flits on the input ports; port p uses slice p |
| in_ready | output | 5 | Input buffer has room |
| out_valid | output | 5 | Flit offered on each output port |
| out_flit | output | 5*(DATA_W+2) | Flits on the output ports; port p uses slice p |
| out_ready | input | 5 | Downstream accepts the flit on each output |

## Verification
Single-flit packets are sent from one port to destinations on every side of the router, including ones that differ in both coordinates. These separate correct column-first ordering from row-first ordering and from local delivery. Two multi-flit packets that race for the same output show whether flits interleave and whether the lock is released without a dead cycle. Three inputs that each send repeated packets to the local port expose the rotation order. A stalled output with a packet in flight shows whether flits are held steady and whether the input buffer pushes back. A long run of random packets under random backpressure is compared against a behavioural queue model on every cycle, which catches any lost, duplicated or reordered flit.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORTS = 5;
  localparam int PIDX_W = 3;

  localparam logic [PIDX_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PIDX_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [PIDX_W-1:0] PORT_EAST  = 3'd2;
  localparam logic [PIDX_W-1:0] PORT_SOUTH = 3'd3;
  localparam logic [PIDX_W-1:0] PORT_WEST  = 3'd4;

  // flit kind, top two bits of a flit (R2): bit 0 marks a head, bit 1 a tail
  localparam logic [1:0] KIND_BODY   = 2'b00;
  localparam logic [1:0] KIND_HEAD   = 2'b01;
  localparam logic [1:0] KIND_TAIL   = 2'b10;
  localparam logic [1:0] KIND_SINGLE = 2'b11;
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ready = (count_q != CW'(DEPTH));
  assign rd_valid = (count_q != '0);
  assign rd_data  = mem[rd_ptr_q];
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && rd_valid;

  always_comb begin
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    count_d  = count_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  // R7: the router never takes a flit from an empty buffer
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> rd_valid);

  // R7: occupancy never exceeds the buffer depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/xy_route.sv
module xy_route
  import router_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int X_POS   = 2,
  parameter int Y_POS   = 2
) (
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output logic [PIDX_W-1:0]  dir
);
  localparam logic [COORD_W-1:0] MY_X = COORD_W'(X_POS);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(Y_POS);

  // R1: column is resolved before row
  always_comb begin
    if (dest_x > MY_X)      dir = PORT_EAST;
    else if (dest_x < MY_X) dir = PORT_WEST;
    else if (dest_y > MY_Y) dir = PORT_NORTH;
    else if (dest_y < MY_Y) dir = PORT_SOUTH;
    else                    dir = PORT_LOCAL;
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] gidx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, ptr_d;
  int            idx;

  always_comb begin
    any  = 1'b0;
    gidx = '0;
    idx  = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any  = 1'b1;
        gidx = IW'(idx);
      end
    end
    grant = any ? (N'(1) << gidx) : '0;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance && any) ptr_d = (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5: at most one winner, and only a requester
  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_winner_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int X_POS      = 2,
  parameter int Y_POS      = 2,
  parameter int COORD_W    = 3,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORTS-1:0]                in_valid,
  input  logic [NPORTS*(DATA_W+2)-1:0]     in_flit,
  output logic [NPORTS-1:0]                in_ready,
  output logic [NPORTS-1:0]                out_valid,
  output logic [NPORTS*(DATA_W+2)-1:0]     out_flit,
  input  logic [NPORTS-1:0]                out_ready
);
  localparam int NP = NPORTS;
  localparam int FW = DATA_W + 2;
  localparam int IW = PIDX_W;

  logic [FW-1:0]     q_flit [NP];
  logic [NP-1:0]     q_valid, q_head, q_tail, pop;
  logic [IW-1:0]     q_dir  [NP];
  logic [NP-1:0]     req    [NP];
  logic [NP-1:0]     grant  [NP];
  logic [IW-1:0]     gidx   [NP];
  logic [NP-1:0]     any, xfer;
  logic [IW-1:0]     src    [NP];
  logic [NP-1:0]     served [NP];
  logic [NP-1:0]     locked_q, locked_d;
  logic [IW-1:0]     owner_q [NP];
  logic [IW-1:0]     owner_d [NP];

  // input side: buffer plus route of the buffered head flit
  for (genvar i = 0; i < NP; i++) begin : g_in
    flit_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid[i]),
      .wr_data  (in_flit[i*FW +: FW]),
      .wr_ready (in_ready[i]),
      .rd_valid (q_valid[i]),
      .rd_data  (q_flit[i]),
      .rd_pop   (pop[i])
    );
    xy_route #(.COORD_W(COORD_W), .X_POS(X_POS), .Y_POS(Y_POS)) u_route (
      .dest_x (q_flit[i][COORD_W-1:0]),
      .dest_y (q_flit[i][2*COORD_W-1:COORD_W]),
      .dir    (q_dir[i])
    );
    assign q_head[i] = q_flit[i][FW-2];
    assign q_tail[i] = q_flit[i][FW-1];
  end

  // head flits request the output their route names, if it is free
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req[o][i] = q_valid[i] && q_head[i] && (q_dir[i] == IW'(o)) && !locked_q[o];
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    rr_arbiter #(.N(NP)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[o]),
      .advance (!locked_q[o]),
      .grant   (grant[o]),
      .gidx    (gidx[o]),
      .any     (any[o])
    );
  end

  // crossbar: locked outputs follow their owner, free ones the arbiter winner
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      src[o]              = locked_q[o] ? owner_q[o] : gidx[o];
      out_valid[o]        = (locked_q[o] || any[o]) && q_valid[src[o]];
      out_flit[o*FW +: FW] = q_flit[src[o]];
      xfer[o]             = out_valid[o] && out_ready[o];
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++) begin
        served[i][o] = xfer[o] && (src[o] == IW'(i));
      end
      pop[i] = |served[i];
    end
  end

  // path lock: claimed by a head, freed as the tail is accepted (R3, R4)
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      locked_d[o] = locked_q[o];
      owner_d[o]  = owner_q[o];
      if (locked_q[o]) begin
        if (xfer[o] && q_tail[src[o]]) locked_d[o] = 1'b0;
      end else if (any[o]) begin
        owner_d[o]  = gidx[o];
        locked_d[o] = !(xfer[o] && q_tail[src[o]]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= '0;
      for (int o = 0; o < NP; o++) owner_q[o] <= '0;
    end else begin
      locked_q <= locked_d;
      for (int o = 0; o < NP; o++) owner_q[o] <= owner_d[o];
    end
  end

  // R6: a stalled output keeps its flit
  for (genvar o = 0; o < NP; o++) begin : g_chk_out
    assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FW +: FW]));
  end

  // R3: an input feeds at most one output per cycle
  for (genvar i = 0; i < NP; i++) begin : g_chk_in
    assert_single_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(served[i]));
  end

  // R1: checked at the ports against the coordinates carried by the flit
  logic [FW-1:0] east_f, local_f;
  assign east_f  = out_flit[2*FW +: FW];
  assign local_f = out_flit[0 +: FW];

  assert_east_column_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] && east_f[FW-2] |-> east_f[COORD_W-1:0] > COORD_W'(X_POS));
  assert_local_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] && local_f[FW-2] |->
      local_f[COORD_W-1:0] == COORD_W'(X_POS) &&
      local_f[2*COORD_W-1:COORD_W] == COORD_W'(Y_POS));
endmodule

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
  localparam int NP = 5;
  localparam int C  = 3;
  localparam int DW = 16;
  localparam int FW = DW + 2;
  localparam int XP = 2;
  localparam int YP = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     in_valid, in_ready, out_valid, out_ready;
  logic [NP*FW-1:0]  in_flit, out_flit;

  mesh_router #(.X_POS(XP), .Y_POS(YP), .COORD_W(C), .DATA_W(DW), .FIFO_DEPTH(2)) u0 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_flit (in_flit), .in_ready (in_ready),
    .out_valid (out_valid), .out_flit (out_flit), .out_ready (out_ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R9";
  logic [FW-1:0] sq [NP][$];
  logic [FW-1:0] mq [NP][$];
  bit  mlock [NP];
  int  mown [NP];
  int  mptr [NP];
  bit  ev [NP];
  bit  eg [NP];
  int  es [NP];
  bit  in_pkt [NP];
  int  span_cnt, span_first, span_last;
  int  rr_seq [$];
  bit  rec_rr = 0;
  int  sent_total = 0, recv_total = 0;
  bit  rand_ready = 0;
  logic [NP-1:0] ready_mask = '1;
  int  next_tag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int route(input logic [FW-1:0] f);
    int x, y;
    x = int'(f[C-1:0]);
    y = int'(f[2*C-1:C]);
    if (x > XP) return 2;
    if (x < XP) return 4;
    if (y > YP) return 1;
    if (y < YP) return 3;
    return 0;
  endfunction

  task automatic model_eval();
    for (int o = 0; o < NP; o++) begin
      eg[o] = 0; ev[o] = 0; es[o] = 0;
      if (mlock[o]) begin
        es[o] = mown[o];
        ev[o] = mq[es[o]].size() > 0;
      end else begin
        for (int k = 0; k < NP; k++) begin
          int i;
          i = (mptr[o] + k) % NP;
          if (!eg[o] && mq[i].size() > 0 && mq[i][0][FW-2] && route(mq[i][0]) == o) begin
            eg[o] = 1; es[o] = i;
          end
        end
        ev[o] = eg[o];
      end
    end
  endtask

  task automatic compare();
    logic [FW-1:0] f;
    for (int i = 0; i < NP; i++)
      check(in_ready[i] == (mq[i].size() < 2), "R7", $sformatf("in_ready[%0d]", i),
            in_ready[i], mq[i].size() < 2);
    for (int o = 0; o < NP; o++) begin
      check(out_valid[o] == ev[o], tag, $sformatf("out_valid[%0d]", o), out_valid[o], ev[o]);
      if (ev[o] && out_valid[o])
        check(out_flit[o*FW +: FW] == mq[es[o]][0], tag, $sformatf("out_flit[%0d]", o),
              out_flit[o*FW +: FW], mq[es[o]][0]);
      if (out_valid[o] && out_ready[o]) begin
        f = out_flit[o*FW +: FW];
        recv_total++;
        if (f[FW-2]) begin
          check(route(f) == o, "R1", $sformatf("head left port %0d", o), o, route(f));
          check(!in_pkt[o], "R3", $sformatf("head inside open packet on %0d", o), 1, 0);
          in_pkt[o] = !f[FW-1];
        end else begin
          check(in_pkt[o], "R2", $sformatf("orphan body/tail on %0d", o), 0, 1);
          if (f[FW-1]) in_pkt[o] = 0;
        end
        if (o == 2) begin
          if (span_first < 0) span_first = cyc;
          span_last = cyc;
          span_cnt++;
        end
        if (rec_rr && o == 0) rr_seq.push_back(int'(f[15:12]));
      end
    end
  endtask

  task automatic model_update();
    int sz [NP];
    logic [FW-1:0] f;
    bit x, t;
    for (int i = 0; i < NP; i++) sz[i] = mq[i].size();
    for (int o = 0; o < NP; o++) begin
      x = ev[o] && out_ready[o];
      t = 0;
      if (x) begin
        f = mq[es[o]].pop_front();
        t = f[FW-1];
      end
      if (mlock[o]) begin
        if (x && t) mlock[o] = 0;
      end else if (eg[o]) begin
        mown[o]  = es[o];
        mptr[o]  = (es[o] + 1) % NP;
        mlock[o] = !(x && t);
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (in_valid[i] && sz[i] < 2) begin
        mq[i].push_back(in_flit[i*FW +: FW]);
        void'(sq[i].pop_front());
        sent_total++;
      end
    end
  endtask

  task automatic drive();
    for (int i = 0; i < NP; i++) begin
      in_valid[i]          = sq[i].size() > 0;
      in_flit[i*FW +: FW]  = (sq[i].size() > 0) ? sq[i][0] : '0;
    end
    for (int o = 0; o < NP; o++)
      out_ready[o] = rand_ready ? ($urandom_range(0, 3) != 0) : ready_mask[o];
  endtask

  task automatic step();
    @(negedge clk);
    drive();
    #2;
    model_eval();
    compare();
    model_update();
  endtask

  function automatic bit busy();
    for (int i = 0; i < NP; i++) if (sq[i].size() > 0 || mq[i].size() > 0) return 1;
    return 0;
  endfunction

  task automatic drain();
    int g;
    g = 0;
    while (busy() && g < 3000) begin step(); g++; end
    check(!busy(), tag, "drain", busy(), 0);
    step(); step();
  endtask

  task automatic push_pkt(input int src, input int dx, input int dy, input int len, input int tg);
    logic [1:0]    kind;
    logic [DW-1:0] d;
    for (int k = 0; k < len; k++) begin
      if (len == 1)          kind = 2'b11;
      else if (k == 0)       kind = 2'b01;
      else if (k == len - 1) kind = 2'b10;
      else                   kind = 2'b00;
      if (k == 0) d = (DW'(tg & 255) << 8) | (DW'(dy) << C) | DW'(dx);
      else        d = (DW'(tg & 255) << 8) | DW'(k);
      sq[src].push_back({kind, d});
    end
  endtask

  task automatic span_reset();
    span_cnt = 0; span_first = -1; span_last = -1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 120000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=120000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int o = 0; o < NP; o++) begin
      mlock[o] = 0; mown[o] = 0; mptr[o] = 0; in_pkt[o] = 0;
    end
    span_reset();
    rst_n = 1'b0; in_valid = '0; in_flit = '0; out_ready = '0;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == '0, "R9", "out_valid in reset", out_valid, 0);
    check(in_ready == '1, "R9", "in_ready in reset", in_ready, 5'h1f);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == '0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == '1, "R9", "in_ready after reset", in_ready, 5'h1f);

    // R1: destinations on every side, column resolved first
    tag = "R1";
    push_pkt(0, 3, 2, 1, 1);
    push_pkt(0, 1, 2, 1, 2);
    push_pkt(0, 2, 3, 1, 3);
    push_pkt(0, 2, 1, 1, 4);
    push_pkt(0, 2, 2, 1, 5);
    push_pkt(0, 5, 0, 1, 6);
    push_pkt(0, 0, 7, 1, 7);
    push_pkt(0, 2, 6, 1, 8);
    push_pkt(4, 2, 0, 1, 9);
    drain();

    // R5: three inputs contend for local output
    tag = "R5";
    rr_seq.delete();
    rec_rr = 1;
    for (int n = 0; n < 2; n++)
      for (int s = 1; s <= 3; s++) push_pkt(s, 2, 2, 1, s * 16 + n);
    drain();
    rec_rr = 0;
    check(rr_seq.size() == 6, "R5", "local deliveries", rr_seq.size(), 6);
    if (rr_seq.size() == 6) begin
      check(rr_seq[0] != rr_seq[1] && rr_seq[1] != rr_seq[2] && rr_seq[0] != rr_seq[2],
            "R5", "first round distinct", rr_seq[0] * 256 + rr_seq[1] * 16 + rr_seq[2], 0);
      check(rr_seq[3] == rr_seq[0] && rr_seq[4] == rr_seq[1] && rr_seq[5] == rr_seq[2],
            "R5", "rotation repeats", rr_seq[3] * 256 + rr_seq[4] * 16 + rr_seq[5],
            rr_seq[0] * 256 + rr_seq[1] * 16 + rr_seq[2]);
    end

    // R4: two packets race for east, second head follows tail without a gap
    tag = "R4";
    span_reset();
    push_pkt(1, 6, 2, 3, 40);
    push_pkt(3, 7, 2, 3, 41);
    drain();
    check(span_cnt == 6, "R4", "east flits", span_cnt, 6);
    check(span_last - span_first + 1 == 6, "R4", "east span cycles",
          span_last - span_first + 1, 6);

    // R8: long packet at full rate
    tag = "R8";
    span_reset();
    push_pkt(4, 5, 5, 10, 50);
    drain();
    check(span_cnt == 10, "R8", "east flits", span_cnt, 10);
    check(span_last - span_first + 1 == 10, "R8", "east span cycles",
          span_last - span_first + 1, 10);

    // R6: east stalled with a packet in flight
    tag = "R6";
    ready_mask = 5'b11011;
    push_pkt(4, 6, 2, 4, 60);
    repeat (6) step();
    check(out_valid[2] == 1'b1, "R6", "stalled east valid", out_valid[2], 1);
    check(in_ready[4] == 1'b0, "R7", "west buffer full", in_ready[4], 0);
    ready_mask = '1;
    drain();

    // random traffic under random backpressure
    tag = "R3";
    rand_ready = 1;
    for (int c = 0; c < 1500; c++) begin
      for (int i = 0; i < NP; i++)
        if (sq[i].size() < 3 && $urandom_range(0, 2) == 0) begin
          push_pkt(i, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(1, 4), next_tag);
          next_tag = (next_tag + 1) & 255;
        end
      step();
    end
    rand_ready = 0;
    drain();
    check(sent_total == recv_total, "R6", "flits accepted vs delivered", recv_total, sent_total);

    finish_run();
  end
endmodule